// File: doc/BRIEF.md
# Half-Duplex Data Line Direction Arbiter

This block sits between a host controller and a contact card and joins, for each data line, a host-side open-drain wire to a card-side open-drain wire. Neither side is told which way data flows. While reception is enabled and the lines rest high, the side whose falling edge is seen first becomes the input for that transfer. Its low level is copied onto the other wire by a pull-low enable. When the input side rises again, both pull-low enables drop and the lane returns to its resting state. Pull-ups are external. Each side is modelled as a sampled input plus a pull-low output.

One lane is built per data line, and a parameter sets how many there are, for example one main line and two auxiliary lines. Every line sample passes through a synchronizer before the direction logic sees it. Each transfer therefore reaches the other side a fixed number of clock cycles later. At a 200 MHz clock that delay stays well inside the 25 ns budget for rising edges and the 100 ns budget for falling edges, and it supports data rates up to 1 MHz. While the activation sequencer holds reception off, each card-side wire is held low and the host side is ignored.

Top module: `line_dir_arbiter`

## Requirements
- R1: During and straight after reset, every card-side pull-low output is 1 and every host-side pull-low output is 0.
- R2: While `recv_en` is 0, all card-side pull-lows are 1 and all host-side pull-lows are 0, whatever the host-side lines do. Dropping `recv_en` in the middle of a transfer applies this within the same cycle and ends the transfer.
- R3: With reception on and a lane at rest, a falling edge on the card-side line while the host-side line is high makes the card the input. The host-side pull-low of that lane goes to 1 and its card-side pull-low stays 0.
- R4: With reception on and a lane at rest, a falling edge on the host-side line while the card-side line is high makes the host the input. The card-side pull-low of that lane goes to 1 and its host-side pull-low stays 0.
- R5: When the input side of a lane is seen high again, both pull-low outputs of that lane return to 0.
- R6: While one side is the input, lows and highs on the other side do not change either pull-low output.
- R7: If both lines of a lane are first seen low in the same sampled cycle, the card side becomes the input.
- R8: An input change that is stable before clock edge k shows on the pull-low outputs just after edge k+2, and not just after edge k+1. This is three clock edges with the default two-stage synchronizer.
- R9: Lanes are independent: different lanes can carry transfers in opposite directions at the same time.
- R10: A transfer starts only on a falling edge. A line that is already low when reception is enabled does not start one. Neither does the mirrored side of a lane that is still recovering after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recv_en | input | 1 | Reception enable from the activation sequencer |
| host_line_i | input | LANES | Sampled level of each host-side wire |
| card_line_i | input | LANES | Sampled level of each card-side wire |
| host_pull_o | output | LANES | 1 pulls the host-side wire low |
| card_pull_o | output | LANES | 1 pulls the card-side wire low |

## Verification
The hardest cases to reach are the ones just after a transfer ends. The mirrored wire is still low in the synchronizer while the lane is already back at rest, so a level-based design would start a false transfer in the opposite direction. The same risk applies when both wires fall in one sample. The bench closes the loop with open-drain wire models, in which each wire is the AND of the block's own pull and an external agent's pull. The mirrored low then releases exactly as it would on a board. The bench runs every lane through card-first, host-first, simultaneous, overlapping and aborted transfers. At each step it checks both the cycle before and the cycle of the expected output change.

// File: rtl/line_dir_pkg.sv
package line_dir_pkg;

  typedef enum logic [1:0] {
    DIR_REST    = 2'b00,
    DIR_CARD_IN = 2'b01,
    DIR_HOST_IN = 2'b10
  } dir_state_e;

endpackage

// File: rtl/line_sync_edge.sv
module line_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic fall_o
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;
  logic          prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[LAST];
    end
  end

  assign lvl_o  = chain_q[LAST];
  assign fall_o = prev_q & ~chain_q[LAST];

endmodule

// File: rtl/line_lane_arb.sv
module line_lane_arb
  import line_dir_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recv_en,
  input  logic host_line_i,
  input  logic card_line_i,
  output logic host_pull_o,
  output logic card_pull_o
);

  logic host_s, host_fall, card_s, card_fall;
  dir_state_e st_q, st_d;

  line_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_host_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (host_line_i),
    .lvl_o  (host_s),
    .fall_o (host_fall)
  );

  line_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_card_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (card_line_i),
    .lvl_o  (card_s),
    .fall_o (card_fall)
  );

  always_comb begin
    st_d = st_q;
    if (!recv_en) begin
      st_d = DIR_REST;
    end else begin
      unique case (st_q)
        DIR_REST: begin
          if (card_fall && (host_s || host_fall)) st_d = DIR_CARD_IN;
          else if (host_fall && card_s)          st_d = DIR_HOST_IN;
        end
        DIR_CARD_IN: if (card_s) st_d = DIR_REST;
        DIR_HOST_IN: if (host_s) st_d = DIR_REST;
        default:     st_d = DIR_REST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DIR_REST;
    else        st_q <= st_d;
  end

  assign host_pull_o = recv_en && (st_q == DIR_CARD_IN);
  assign card_pull_o = !recv_en || (st_q == DIR_HOST_IN);

  assert_rx_off_rests_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !recv_en |=> st_q == DIR_REST);

  assert_card_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (recv_en && st_q == DIR_REST && card_fall && host_s) |=> st_q == DIR_CARD_IN);

  assert_host_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (recv_en && st_q == DIR_REST && host_fall && card_s) |=> st_q == DIR_HOST_IN);

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != DIR_REST && ((st_q == DIR_CARD_IN) ? card_s : host_s)) |=> st_q == DIR_REST);

  assert_hold_while_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (recv_en && st_q == DIR_CARD_IN && !card_s) |=> st_q == DIR_CARD_IN);

  assert_tie_card_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (recv_en && st_q == DIR_REST && card_fall && host_fall) |=> st_q == DIR_CARD_IN);

  assert_no_direct_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == DIR_HOST_IN |=> st_q != DIR_CARD_IN);

endmodule

// File: rtl/line_dir_arbiter.sv
module line_dir_arbiter #(
  parameter int LANES       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recv_en,
  input  logic [LANES-1:0] host_line_i,
  input  logic [LANES-1:0] card_line_i,
  output logic [LANES-1:0] host_pull_o,
  output logic [LANES-1:0] card_pull_o
);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      line_lane_arb #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .recv_en     (recv_en),
        .host_line_i (host_line_i[g]),
        .card_line_i (card_line_i[g]),
        .host_pull_o (host_pull_o[g]),
        .card_pull_o (card_pull_o[g])
      );
    end
  endgenerate

  assert_no_both_pulled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pull_o & card_pull_o) == '0);

endmodule

// File: tb/tb_line_dir_arbiter.sv
module tb_line_dir_arbiter;

  localparam int L = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic recv_en;
  logic [L-1:0] host_drv, card_drv;
  logic [L-1:0] host_line, card_line, host_pull, card_pull;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign host_line = ~(host_pull | host_drv);
  assign card_line = ~(card_pull | card_drv);

  line_dir_arbiter #(.LANES(L), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .recv_en(recv_en),
    .host_line_i(host_line), .card_line_i(card_line),
    .host_pull_o(host_pull), .card_pull_o(card_pull)
  );

  function automatic logic [L-1:0] bit_of(int k);
    logic [L-1:0] v;
    v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; recv_en = 1'b0; host_drv = '0; card_drv = '0;
    edges(3);
    chk("R1", "card pull in reset", card_pull, '1);
    chk("R1", "host pull in reset", host_pull, '0);
    rst_n = 1'b1;
    edges(1);
    chk("R1", "card pull after reset", card_pull, '1);
    chk("R1", "host pull after reset", host_pull, '0);

    // R2: host activity while reception is off
    host_drv = '1;
    edges(5);
    chk("R2", "card pull rx off", card_pull, '1);
    chk("R2", "host pull rx off", host_pull, '0);
    host_drv = '0;
    edges(5);
    chk("R2", "card pull rx off after host release", card_pull, '1);

    // R10: card wires low until enable, rising on enable
    recv_en = 1'b1;
    edges(6);
    chk("R10", "card pull after enable", card_pull, '0);
    chk("R10", "host pull after enable", host_pull, '0);

    for (int i = 0; i < L; i++) begin
      // R3 / R8 card first
      card_drv = bit_of(i);
      edges(2);
      chk("R8", "host pull one edge early", host_pull, '0);
      edges(1);
      chk("R3", "host pull card-first", host_pull, bit_of(i));
      chk("R3", "card pull card-first", card_pull, '0);
      // R6 output side activity ignored
      host_drv = bit_of(i);
      edges(5);
      chk("R6", "host pull while host agent low", host_pull, bit_of(i));
      host_drv = '0;
      edges(5);
      chk("R6", "host pull after host agent release", host_pull, bit_of(i));
      chk("R6", "card pull unchanged", card_pull, '0);
      // R5 release
      card_drv = '0;
      edges(2);
      chk("R8", "host pull release one edge early", host_pull, bit_of(i));
      edges(1);
      chk("R5", "host pull after card rises", host_pull, '0);
      edges(6);
      chk("R10", "no reverse start after release", card_pull, '0);
      chk("R10", "lane stays at rest", host_pull, '0);

      // R4 host first
      host_drv = bit_of(i);
      edges(2);
      chk("R8", "card pull one edge early", card_pull, '0);
      edges(1);
      chk("R4", "card pull host-first", card_pull, bit_of(i));
      chk("R4", "host pull host-first", host_pull, '0);
      card_drv = bit_of(i);
      edges(4);
      card_drv = '0;
      edges(4);
      chk("R6", "card pull while card agent toggles", card_pull, bit_of(i));
      host_drv = '0;
      edges(3);
      chk("R5", "card pull after host rises", card_pull, '0);
      edges(6);
      chk("R10", "no reverse start after host release", host_pull, '0);

      // R7 simultaneous fall
      host_drv = bit_of(i);
      card_drv = bit_of(i);
      edges(3);
      chk("R7", "host pull on tie", host_pull, bit_of(i));
      chk("R7", "card pull on tie", card_pull, '0);
      card_drv = '0;
      edges(3);
      chk("R7", "host pull after tie release", host_pull, '0);
      edges(4);
      chk("R10", "held host low starts nothing", card_pull, '0);
      host_drv = '0;
      edges(6);
      chk("R10", "rest after tie sequence", host_pull | card_pull, '0);
    end

    // R9 opposite directions on two lanes
    card_drv = bit_of(0);
    host_drv = bit_of(1);
    edges(3);
    chk("R9", "host pulls two lanes", host_pull, bit_of(0));
    chk("R9", "card pulls two lanes", card_pull, bit_of(1));
    card_drv = '0;
    host_drv = '0;
    edges(3);
    chk("R9", "both lanes released", host_pull | card_pull, '0);

    // R2 abort mid-transfer
    card_drv = bit_of(2);
    edges(3);
    chk("R3", "host pull before abort", host_pull, bit_of(2));
    recv_en = 1'b0;
    #1;
    chk("R2", "card pull on abort", card_pull, '1);
    chk("R2", "host pull on abort", host_pull, '0);
    card_drv = '0;
    edges(4);
    recv_en = 1'b1;
    edges(6);
    chk("R2", "rest after re-enable", host_pull | card_pull, '0);

    finish_run();
  end

endmodule